// File: doc/BRIEF.md
# Masked-Write GPIO Bank

This block is one 32-pin general-purpose I/O bank behind a simple register bus (address, write data, write strobe, combinational read data). Output levels are changed through two write-only half-word ports. Each write to one of these ports carries a 16-bit protect mask in its upper half and 16 data bits in its lower half. Every pin whose mask bit is 0 takes the new data bit, and every other pin keeps its level. Software can therefore set or clear any subset of sixteen outputs in one bus write, with no read-modify-write sequence.

Pin levels are read back through a level register fed by a two-flop synchronizer. Two read-write registers control the pad drivers. The direction register selects output (1) or input (0). The output-enable register must also be 1 before the pad is driven. Pins 7 and 8 are hard-wired as outputs: their direction bits always read 1.

Register byte offsets: 0x00 low masked port (pins 0-15), 0x04 high masked port (pins 16-31), 0x08 pin level, 0x0C direction, 0x10 output enable.

Top module: `gpio_mask_bank`

## Requirements
- R1: A write to offset 0x00 loads wdata bit i (0..15) into the output latch of pin i wherever wdata bit 16+i is 0, visible on pad_out after the write edge.
- R2: A write to offset 0x04 loads wdata bit i (0..15) into the output latch of pin 16+i wherever wdata bit 16+i is 0.
- R3: A masked-port write leaves unchanged every pin whose mask bit (wdata bit 16+i) is 1, and never touches the other half.
- R4: Reads of offsets 0x00 and 0x04 return 0.
- R5: Offset 0x08 reads pad_in through a two-flop synchronizer: a change on pad_in appears after the second rising clock edge and not after the first.
- R6: The direction register at 0x0C is read-write, and bit i set to 1 makes pin i an output.
- R7: The output-enable register at 0x10 is read-write. pad_oe[i] is the direction bit AND the output-enable bit, and pad_out carries the output latch.
- R8: Direction bits 7 and 8 always read 1, ignore writes of 0, and count as outputs for pad_oe.
- R9: After reset, the output latch, the direction register (apart from bits 7 and 8) and the output-enable register are 0, so pad_oe is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bank clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 5 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| pad_in | input | 32 | Pin levels from the pads |
| pad_out | output | 32 | Output latch value to the pads |
| pad_oe | output | 32 | Per-pin pad drive enable |

## Verification
The bench builds the bank with its defaults: 16-bit half words, which give 32 pins, and pins 7 and 8 forced to output. With these values both masked ports run through full, partial, interleaved and all-protected masks, so that each half is shown to keep the other half's bits. The forced pair straddles the first byte boundary, where a wrong forced-bit constant or a byte-wide slice error shows up. The two-stage latency is checked on both sides of the second edge.

// File: rtl/gpio_mask_pkg.sv
package gpio_mask_pkg;
  localparam int unsigned ADDR_W = 5;
  localparam logic [ADDR_W-1:0] ADR_WR_LO = 5'h00;
  localparam logic [ADDR_W-1:0] ADR_WR_HI = 5'h04;
  localparam logic [ADDR_W-1:0] ADR_LEVEL = 5'h08;
  localparam logic [ADDR_W-1:0] ADR_DIR   = 5'h0C;
  localparam logic [ADDR_W-1:0] ADR_OE    = 5'h10;

  // byte offset of masked half-word port h
  function automatic logic [ADDR_W-1:0] half_port_addr(input int unsigned h);
    return ADDR_W'(4 * h);
  endfunction
endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb stage_d = {stage_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= stage_d;
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] chain_q [STAGES];
  logic [WIDTH-1:0] chain_d [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_comb chain_d[s] = async_in;
      end else begin : g_next
        always_comb chain_d[s] = chain_q[s-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[s] <= '0;
        else        chain_q[s] <= chain_d[s];
      end
    end
  endgenerate

  assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_out_latch.sv
module gpio_out_latch
  import gpio_mask_pkg::*;
#(
  parameter int unsigned HALF_W = 16,
  localparam int unsigned NUM_HALVES = 2,
  localparam int unsigned PINS = HALF_W * NUM_HALVES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [PINS-1:0]   bus_wdata,
  input  logic              bus_we,
  output logic [PINS-1:0]   latch_q
);
  genvar h;
  generate
    for (h = 0; h < NUM_HALVES; h++) begin : g_half
      localparam logic [ADDR_W-1:0] PORT_ADDR = half_port_addr(h);
      logic [HALF_W-1:0] keep_mask;
      logic [HALF_W-1:0] new_bits;
      logic [HALF_W-1:0] half_q;
      logic [HALF_W-1:0] half_d;
      logic              hit;

      always_comb begin
        keep_mask = bus_wdata[PINS-1 -: HALF_W];
        new_bits  = bus_wdata[HALF_W-1:0];
        hit       = bus_we && (bus_addr == PORT_ADDR);
        half_d    = (half_q & keep_mask) | (new_bits & ~keep_mask);
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   half_q <= '0;
        else if (hit) half_q <= half_d;
      end

      assign latch_q[h*HALF_W +: HALF_W] = half_q;
    end
  endgenerate
endmodule

// File: rtl/gpio_ctrl_regs.sv
module gpio_ctrl_regs
  import gpio_mask_pkg::*;
#(
  parameter int unsigned PINS = 32,
  parameter logic [PINS-1:0] FORCED_OUT = 32'h0000_0180
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [PINS-1:0]   bus_wdata,
  input  logic              bus_we,
  output logic [PINS-1:0]   dir_rd,
  output logic [PINS-1:0]   oe_rd,
  output logic [PINS-1:0]   drive_en
);
  logic [PINS-1:0] dir_q, dir_d;
  logic [PINS-1:0] oe_q, oe_d;
  logic            dir_en, oe_en;

  always_comb begin
    dir_en = bus_we && (bus_addr == ADR_DIR);
    oe_en  = bus_we && (bus_addr == ADR_OE);
    dir_d  = bus_wdata;
    oe_d   = bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dir_q <= '0;
    else if (dir_en) dir_q <= dir_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     oe_q <= '0;
    else if (oe_en) oe_q <= oe_d;
  end

  assign dir_rd   = dir_q | FORCED_OUT;
  assign oe_rd    = oe_q;
  assign drive_en = dir_rd & oe_q;
endmodule

// File: rtl/gpio_mask_bank.sv
module gpio_mask_bank
  import gpio_mask_pkg::*;
#(
  parameter int unsigned HALF_W = 16,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [2*HALF_W-1:0] FORCED_OUT = 32'h0000_0180,
  localparam int unsigned PINS = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [PINS-1:0]   bus_wdata,
  input  logic              bus_we,
  output logic [PINS-1:0]   bus_rdata,
  input  logic [PINS-1:0]   pad_in,
  output logic [PINS-1:0]   pad_out,
  output logic [PINS-1:0]   pad_oe
);
  logic            rst_sync_n;
  logic [PINS-1:0] level_sync;
  logic [PINS-1:0] dir_rd, oe_rd;

  gpio_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  gpio_in_sync #(.WIDTH(PINS), .STAGES(SYNC_STAGES)) u_insync (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .async_in (pad_in),
    .sync_out (level_sync)
  );

  gpio_out_latch #(.HALF_W(HALF_W)) u_latch (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_we    (bus_we),
    .latch_q   (pad_out)
  );

  gpio_ctrl_regs #(.PINS(PINS), .FORCED_OUT(FORCED_OUT)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_we    (bus_we),
    .dir_rd    (dir_rd),
    .oe_rd     (oe_rd),
    .drive_en  (pad_oe)
  );

  // masked ports are write-only and fall to the default arm
  always_comb begin
    unique case (bus_addr)
      ADR_LEVEL: bus_rdata = level_sync;
      ADR_DIR:   bus_rdata = dir_rd;
      ADR_OE:    bus_rdata = oe_rd;
      default:   bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio_mask_bank_chk.sv
module gpio_mask_bank_chk
  import gpio_mask_pkg::*;
#(
  parameter int unsigned HALF_W = 16,
  localparam int unsigned PINS = 2 * HALF_W
) (
  input logic              clk,
  input logic              rst_ok_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [PINS-1:0]   bus_wdata,
  input logic              bus_we,
  input logic [PINS-1:0]   bus_rdata,
  input logic [PINS-1:0]   pad_out
);
  // R1: unprotected low-half bits take the written data
  assert_low_load_R1: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (bus_we && bus_addr == ADR_WR_LO) |=>
      ((pad_out[HALF_W-1:0] & ~$past(bus_wdata[PINS-1:HALF_W])) ==
       ($past(bus_wdata[HALF_W-1:0]) & ~$past(bus_wdata[PINS-1:HALF_W]))));

  // R2: unprotected high-half bits take the written data
  assert_high_load_R2: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (bus_we && bus_addr == ADR_WR_HI) |=>
      ((pad_out[PINS-1:HALF_W] & ~$past(bus_wdata[PINS-1:HALF_W])) ==
       ($past(bus_wdata[HALF_W-1:0]) & ~$past(bus_wdata[PINS-1:HALF_W]))));

  // R3: protected low-half bits and the whole other half hold
  assert_low_keep_R3: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (bus_we && bus_addr == ADR_WR_LO) |=>
      (((pad_out[HALF_W-1:0] ^ $past(pad_out[HALF_W-1:0])) & $past(bus_wdata[PINS-1:HALF_W])) == '0)
      && $stable(pad_out[PINS-1:HALF_W]));

  // R4: masked ports read as zero
  assert_wo_read_zero_R4: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (bus_addr == ADR_WR_LO || bus_addr == ADR_WR_HI) |-> (bus_rdata == '0));

  // R8: forced-output pins always read back as outputs
  assert_forced_dir_R8: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (bus_addr == ADR_DIR) |-> (bus_rdata[8:7] == 2'b11));
endmodule

bind gpio_mask_bank gpio_mask_bank_chk #(.HALF_W(HALF_W)) u_chk (
  .clk       (clk),
  .rst_ok_n  (rst_sync_n),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_we    (bus_we),
  .bus_rdata (bus_rdata),
  .pad_out   (pad_out)
);

// File: tb/sim_gpio_mask_bank.sv
`timescale 1ns/1ps
module sim_gpio_mask_bank;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [4:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic        bus_we;
  logic [31:0] bus_rdata;
  logic [31:0] pad_in;
  logic [31:0] pad_out;
  logic [31:0] pad_oe;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  gpio_mask_bank u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe)
  );

  typedef struct packed {
    logic [4:0]  addr;
    logic [31:0] wdata;
    logic [31:0] exp_out;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{5'h00, 32'h0000_A5A5, 32'h0000_A5A5},  // R1 full low write
    '{5'h04, 32'h0000_1234, 32'h1234_A5A5},  // R2 full high write
    '{5'h00, 32'hFF00_00FF, 32'h1234_A5FF},  // R3 upper byte protected
    '{5'h04, 32'h00FF_FFFF, 32'hFF34_A5FF},  // R3 lower byte protected
    '{5'h00, 32'hFFFF_0000, 32'hFF34_A5FF},  // R3 everything protected
    '{5'h04, 32'h0F0F_0000, 32'h0F04_A5FF},  // R2 interleaved clear
    '{5'h00, 32'h5555_0000, 32'h0F04_0555}   // R1 alternate-bit clear
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    bus_addr = a;
    #0.5;
    d = bus_rdata;
  endtask

  initial begin
    logic [31:0] r;
    rst_n = 1'b0; bus_addr = '0; bus_wdata = '0; bus_we = 1'b0; pad_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R9 reset state
    check("R9 pad_out", pad_out, 32'h0);
    check("R9 pad_oe", pad_oe, 32'h0);
    rd(5'h0C, r); check("R9 dir", r, 32'h0000_0180);
    rd(5'h10, r); check("R9 oe", r, 32'h0);

    for (int i = 0; i < NV; i++) begin
      wr(VECS[i].addr, VECS[i].wdata);
      check($sformatf("R1/R2/R3 vec%0d", i), pad_out, VECS[i].exp_out);
    end

    // R4 write-only ports read zero
    rd(5'h00, r); check("R4 low", r, 32'h0);
    rd(5'h04, r); check("R4 high", r, 32'h0);

    // R5 two-stage latency
    @(negedge clk); pad_in = 32'hDEAD_BEEF;
    @(negedge clk); rd(5'h08, r); check("R5 one edge", r, 32'h0);
    @(negedge clk); rd(5'h08, r); check("R5 two edges", r, 32'hDEAD_BEEF);

    // R6 direction read-write
    wr(5'h0C, 32'hA000_FFFF);
    rd(5'h0C, r); check("R6 dir", r, 32'hA000_FFFF);
    check("R6 no oe", pad_oe, 32'h0);

    // R8 forced pins survive a zero write
    wr(5'h0C, 32'h0);
    rd(5'h0C, r); check("R8 dir", r, 32'h0000_0180);

    // R7 output enable and drive
    wr(5'h10, 32'hFFFF_FFFF);
    rd(5'h10, r); check("R7 oe rb", r, 32'hFFFF_FFFF);
    check("R8 forced drive", pad_oe, 32'h0000_0180);
    wr(5'h0C, 32'hF000_0000);
    check("R7 and", pad_oe, 32'hF000_0180);
    wr(5'h10, 32'h0000_0F00);
    check("R7 oe gate", pad_oe, 32'h0000_0100);
    check("R7 pad_out", pad_out, 32'h0F04_0555);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule